// File: doc/BRIEF.md
# I2C Interrupt Flag Controller

This block holds the interrupt flags and enables of an I2C serial interface and turns them into interrupt requests for a CPU. It receives single-cycle event pulses from the I2C protocol engine: transmit buffer free, byte received, NACK, START, STOP, own-address match and arbitration lost. From these events, and from CPU buffer accesses, it sets and clears six flags. Each flag follows its own rules.

The flags are split into two request groups. The data group holds the transmit and receive flags. The state group holds the arbitration-lost, NACK, START and STOP flags. Each group drives its own request line, gated by the per-flag enables and by a global interrupt enable. The transmit and receive flags are also exported as DMA triggers. When arbitration is lost, a one-cycle master-mode clear pulse tells the engine to fall back to slave operation.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: While `rstN` is low, all flags, all enables, both request lines, both DMA triggers and `mstClear` are 0.
- R2: The flag vector uses bit 0 = transmit, bit 1 = receive, bit 2 = arbitration lost, bit 3 = NACK, bit 4 = START, bit 5 = STOP. `dataIrq` is 1 exactly when `gie` is 1 and bit 0 or bit 1 is set together with its enable. `stateIrq` is 1 exactly when `gie` is 1 and one of bits 2 to 5 is set together with its enable.
- R3: `evTxFree` sets the transmit flag. `txWrite` or `evNack` clears it.
- R4: While `swReset` is 1, the transmit flag is forced to 1 when `i2cMode` is 1. The receive flag and the enables in bits 0 and 1 are cleared, and the other flags are unaffected.
- R5: `evRxByte` sets the receive flag and `rxRead` clears it. When `swReset` is 1, the clear wins over `evRxByte`.
- R6: `evArbLost` sets the arbitration-lost flag, and `mstClear` is 1 for exactly the cycle after each `evArbLost` pulse.
- R7: `evNack` sets the NACK flag and `evStart` clears it.
- R8: The START flag is set by `evAddrMatch` only when `masterMode` is 0 and a START has been seen (in the same cycle, or earlier with no STOP or address match since). `evStop` clears it.
- R9: `evStop` sets the STOP flag only when `masterMode` is 0, and `evStart` clears it.
- R10: A `flagWrite` clears every flag whose bit in `flagWrData` is 0. In any cycle, a hardware set wins over every clear except the `swReset` clear of R5. An `ieWrite` loads `ieWrData` into the enables, and the R4 clear takes priority over it.
- R11: `dmaTxReq` and `dmaRxReq` equal the transmit and receive flags.
- R12: Every flag, enable and `mstClear` change caused by inputs sampled at a clock edge becomes visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-up clear, active low, asynchronous |
| swReset | input | 1 | Software reset bit |
| i2cMode | input | 1 | I2C mode selected |
| masterMode | input | 1 | Interface is currently master |
| gie | input | 1 | Global interrupt enable |
| evTxFree | input | 1 | Transmit buffer can take a byte |
| evRxByte | input | 1 | Received byte loaded |
| evNack | input | 1 | Expected acknowledge missing |
| evStart | input | 1 | START condition detected |
| evStop | input | 1 | STOP condition detected |
| evAddrMatch | input | 1 | Own address matched |
| evArbLost | input | 1 | Arbitration lost |
| txWrite | input | 1 | CPU wrote the transmit buffer |
| rxRead | input | 1 | CPU read the receive buffer |
| flagWrite | input | 1 | CPU write to the flag register |
| flagWrData | input | 6 | Flag write data, 0 bits clear |
| ieWrite | input | 1 | CPU write to the enable register |
| ieWrData | input | 6 | Enable write data |
| flags | output | 6 | Flag vector |
| ie | output | 6 | Enable vector |
| dataIrq | output | 1 | Data request line |
| stateIrq | output | 1 | State-change request line |
| dmaTxReq | output | 1 | Transmit DMA trigger |
| dmaRxReq | output | 1 | Receive DMA trigger |
| mstClear | output | 1 | Master-mode clear pulse |

## Verification
The bench targets collisions between sets and clears in one cycle:
- A byte arriving during a software reset: a design that lets the set win would leave a stale receive flag after reset.
- A transmit-free event in the same cycle as a NACK or a buffer write: a design that lets the clear win would drop a transmit request.
- START and STOP in the same cycle, and START followed by an address match in master mode: a design that gets these wrong would leave a phantom START or STOP flag.
- Arbitration loss: a late or stretched master-clear pulse would show up as a mismatch against the one-cycle reference.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int TX_B = 0;
  localparam int RX_B = 1;
  localparam int AL_B = 2;
  localparam int NK_B = 3;
  localparam int ST_B = 4;
  localparam int SP_B = 5;

  typedef logic [NUM_FLAGS-1:0] flagVecT;

  localparam flagVecT DATA_MASK  = flagVecT'((1 << TX_B) | (1 << RX_B));
  localparam flagVecT STATE_MASK = ~DATA_MASK;

  typedef struct packed {
    flagVecT setVec;
    flagVecT clrVec;
    logic    ieLoad;
    flagVecT ieData;
    logic    ieDataClr;
  } dpStrobeT;
endpackage

// File: rtl/i2c_irq_ctl.sv
module i2c_irq_ctl
  import i2c_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swReset,
  input  logic     i2cMode,
  input  logic     masterMode,
  input  logic     evTxFree,
  input  logic     evRxByte,
  input  logic     evNack,
  input  logic     evStart,
  input  logic     evStop,
  input  logic     evAddrMatch,
  input  logic     evArbLost,
  input  logic     txWrite,
  input  logic     rxRead,
  input  logic     flagWrite,
  input  flagVecT  flagWrData,
  input  logic     ieWrite,
  input  flagVecT  ieWrData,
  output dpStrobeT strobe,
  output logic     mstClear
);
  logic    startPend;
  flagVecT swClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPend <= 1'b0;
      mstClear  <= 1'b0;
    end else begin
      mstClear <= evArbLost;
      if (evStop || evAddrMatch) startPend <= 1'b0;
      else if (evStart)          startPend <= 1'b1;
    end
  end

  assign swClr = flagWrite ? ~flagWrData : '0;

  always_comb begin
    strobe = '0;
    strobe.setVec[TX_B] = evTxFree | (swReset & i2cMode);
    strobe.clrVec[TX_B] = txWrite | evNack;
    strobe.setVec[RX_B] = evRxByte & ~swReset;
    strobe.clrVec[RX_B] = swReset | rxRead;
    strobe.setVec[AL_B] = evArbLost;
    strobe.setVec[NK_B] = evNack;
    strobe.clrVec[NK_B] = evStart;
    strobe.setVec[ST_B] = evAddrMatch & ~masterMode & (startPend | evStart);
    strobe.clrVec[ST_B] = evStop;
    strobe.setVec[SP_B] = evStop & ~masterMode;
    strobe.clrVec[SP_B] = evStart;
    strobe.clrVec       = strobe.clrVec | swClr;
    strobe.ieLoad       = ieWrite;
    strobe.ieData       = ieWrData;
    strobe.ieDataClr    = swReset;
  end
endmodule

// File: rtl/i2c_irq_dp.sv
module i2c_irq_dp
  import i2c_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     gie,
  input  dpStrobeT strobe,
  output flagVecT  flags,
  output flagVecT  ie,
  output logic     dataIrq,
  output logic     stateIrq
);
  flagVecT flagsQ;
  flagVecT ieQ;
  flagVecT pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~strobe.clrVec) | strobe.setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ <= '0;
    end else begin
      if (strobe.ieLoad)    ieQ <= strobe.ieData;
      if (strobe.ieDataClr) ieQ <= (strobe.ieLoad ? strobe.ieData : ieQ) & ~DATA_MASK;
    end
  end

  assign pending  = flagsQ & ieQ;
  assign dataIrq  = gie & |(pending & DATA_MASK);
  assign stateIrq = gie & |(pending & STATE_MASK);
  assign flags    = flagsQ;
  assign ie       = ieQ;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       i2cMode,
  input  logic       masterMode,
  input  logic       gie,
  input  logic       evTxFree,
  input  logic       evRxByte,
  input  logic       evNack,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evAddrMatch,
  input  logic       evArbLost,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       flagWrite,
  input  logic [5:0] flagWrData,
  input  logic       ieWrite,
  input  logic [5:0] ieWrData,
  output logic [5:0] flags,
  output logic [5:0] ie,
  output logic       dataIrq,
  output logic       stateIrq,
  output logic       dmaTxReq,
  output logic       dmaRxReq,
  output logic       mstClear
);
  dpStrobeT strobe;

  i2c_irq_ctl uCtl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .i2cMode(i2cMode),
    .masterMode(masterMode), .evTxFree(evTxFree), .evRxByte(evRxByte),
    .evNack(evNack), .evStart(evStart), .evStop(evStop),
    .evAddrMatch(evAddrMatch), .evArbLost(evArbLost), .txWrite(txWrite),
    .rxRead(rxRead), .flagWrite(flagWrite), .flagWrData(flagWrData),
    .ieWrite(ieWrite), .ieWrData(ieWrData), .strobe(strobe),
    .mstClear(mstClear)
  );

  i2c_irq_dp uDp (
    .clk(clk), .rstN(rstN), .gie(gie), .strobe(strobe), .flags(flags),
    .ie(ie), .dataIrq(dataIrq), .stateIrq(stateIrq)
  );

  assign dmaTxReq = flags[TX_B];
  assign dmaRxReq = flags[RX_B];

  AST_TX_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    swReset && i2cMode |=> flags[TX_B]); // R4
  AST_SWRST_IE: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> ie[RX_B:TX_B] == 2'b00 && !flags[RX_B]); // R4
  AST_NACK_TXCLR: assert property (@(posedge clk) disable iff (!rstN)
    evNack && !evTxFree && !(swReset && i2cMode) |=> !flags[TX_B]); // R3
  AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (!rstN)
    rxRead && !evRxByte |=> !flags[RX_B]); // R5
  AST_ARB_MCLR: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> mstClear && flags[AL_B]); // R6
  AST_MCLR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !evArbLost |=> !mstClear); // R6
  AST_START_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && !flags[ST_B] |=> !flags[ST_B]); // R8
  AST_STOP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    evStart && !(evStop && !masterMode) |=> !flags[SP_B]); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> !dataIrq && !stateIrq); // R2
endmodule

// File: tb/i2c_irq_ctrl_test.sv
module i2c_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReset = 0, i2cMode = 1, masterMode = 0, gie = 0;
  logic evTxFree = 0, evRxByte = 0, evNack = 0, evStart = 0, evStop = 0;
  logic evAddrMatch = 0, evArbLost = 0, txWrite = 0, rxRead = 0;
  logic flagWrite = 0, ieWrite = 0;
  logic [5:0] flagWrData = 0, ieWrData = 0;
  logic [5:0] flags, ie;
  logic dataIrq, stateIrq, dmaTxReq, dmaRxReq, mstClear;

  int checks = 0;
  int errors = 0;

  // reference state
  bit [5:0] mF, mIe;
  bit mPend, mMclr;
  string flagReq [6] = '{"R3", "R5", "R6", "R7", "R8", "R9"};

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_ctrl uut (.*);

  task automatic chk(string req, string what, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %b exp %b", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int b = 0; b < 6; b++) chk(flagReq[b], "flag", 6'(flags[b]), 6'(mF[b]));
    chk("R10", "enables", ie, mIe);
    chk("R2", "dataIrq", 6'(dataIrq), 6'(gie && ((mF[0] && mIe[0]) || (mF[1] && mIe[1]))));
    chk("R2", "stateIrq", 6'(stateIrq), 6'(gie && ((mF[5:2] & mIe[5:2]) != 0)));
    chk("R11", "dma", {4'b0, dmaRxReq, dmaTxReq}, {4'b0, mF[1], mF[0]});
    chk("R6", "mstClear", 6'(mstClear), 6'(mMclr));
  endtask

  // one clock; reference next state computed from inputs (R12: visible right after edge)
  task automatic step();
    bit [5:0] nF, nIe;
    bit nPend;
    nF = mF; nIe = mIe; nPend = mPend;
    if (!rstN) begin
      nF = 0; nIe = 0; nPend = 0;
    end else begin
      for (int b = 0; b < 6; b++) if (flagWrite && !flagWrData[b]) nF[b] = 0;
      if (txWrite || evNack) nF[0] = 0;
      if (evTxFree || (swReset && i2cMode)) nF[0] = 1;
      if (rxRead) nF[1] = 0;
      if (evRxByte) nF[1] = 1;
      if (swReset) nF[1] = 0;
      if (evArbLost) nF[2] = 1;
      if (evStart) nF[3] = 0;
      if (evNack) nF[3] = 1;
      if (evStop) nF[4] = 0;
      if (evAddrMatch && !masterMode && (mPend || evStart)) nF[4] = 1;
      if (evStart) nF[5] = 0;
      if (evStop && !masterMode) nF[5] = 1;
      if (evStop || evAddrMatch) nPend = 0;
      else if (evStart) nPend = 1;
      if (ieWrite) nIe = ieWrData;
      if (swReset) nIe[1:0] = 0;
    end
    @(posedge clk);
    #1;
    mF = nF; mIe = nIe; mPend = nPend;
    mMclr = rstN && evArbLost;
    compareAll();
  endtask

  task automatic idle();
    swReset = 0; evTxFree = 0; evRxByte = 0; evNack = 0; evStart = 0;
    evStop = 0; evAddrMatch = 0; evArbLost = 0; txWrite = 0; rxRead = 0;
    flagWrite = 0; ieWrite = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", "flags in reset", flags, 6'b0);
    chk("R1", "mstClear in reset", {5'b0, mstClear}, 6'b0);
    rstN = 1;
    gie = 1;
    // R4: software reset forces transmit flag and clears data enables
    ieWrite = 1; ieWrData = 6'h3f; step(); idle();
    swReset = 1; evRxByte = 1; step(); idle();
    chk("R4", "tx forced", 6'(flags[0]), 6'b1);
    chk("R4", "data enables", {4'b0, ie[1:0]}, 6'b0);
    chk("R4", "rx cleared over set", 6'(flags[1]), 6'b0);
    // R8: START then address match in slave mode
    evStart = 1; step(); idle();
    evAddrMatch = 1; step(); idle();
    chk("R8", "start flag", 6'(flags[4]), 6'b1);
    chk("R2", "stateIrq", 6'(stateIrq), 6'b1);
    // R8: match in master mode after START leaves flag clear
    flagWrite = 1; flagWrData = 6'h0f; step(); idle();
    masterMode = 1; evStart = 1; step(); idle();
    evAddrMatch = 1; step(); idle();
    chk("R8", "no start in master", 6'(flags[4]), 6'b0);
    masterMode = 0;
    // R6: arbitration loss pulse
    evArbLost = 1; step(); idle();
    chk("R6", "mstClear pulse", 6'(mstClear), 6'b1);
    step();
    chk("R6", "mstClear drop", 6'(mstClear), 6'b0);
    // R10: set wins over software clear
    flagWrite = 1; flagWrData = 6'h00; evNack = 1; step(); idle();
    chk("R10", "nack set wins", 6'(flags[3]), 6'b1);
    // random phase
    for (int i = 0; i < RAND_CYCLES; i++) begin
      swReset     = ($urandom % 40) == 0;
      i2cMode     = ($urandom % 8) != 0;
      if (($urandom % 16) == 0) masterMode = ~masterMode;
      gie         = ($urandom % 6) != 0;
      evTxFree    = ($urandom % 6) == 0;
      evRxByte    = ($urandom % 6) == 0;
      evNack      = ($urandom % 10) == 0;
      evStart     = ($urandom % 8) == 0;
      evStop      = ($urandom % 10) == 0;
      evAddrMatch = ($urandom % 5) == 0;
      evArbLost   = ($urandom % 12) == 0;
      txWrite     = ($urandom % 6) == 0;
      rxRead      = ($urandom % 6) == 0;
      flagWrite   = ($urandom % 8) == 0;
      flagWrData  = 6'($urandom);
      ieWrite     = ($urandom % 10) == 0;
      ieWrData    = 6'($urandom);
      if (i == RAND_CYCLES / 2) rstN = 0;
      if (i == RAND_CYCLES / 2 + 2) rstN = 1;
      step();
      if (!rstN) chk("R1", "flags during reset", flags, 6'b0);
    end
    idle();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule